// File: doc/BRIEF.md
# Soft-Start and Fault Shutdown Sequencer

This block owns the digital soft-start level of a phase-shifted bridge PWM controller. The level caps the PWM control word. The block also decides how the controller responds to four kinds of fault: an undervoltage on the supply, a reference that is not good, an overcurrent trip and an external disable request.

A supply sample passes through a lockout comparator with hysteresis. The lockout and a bad reference are treated as hard faults: the level drops to zero on the next edge. An overcurrent trip turns the outputs off and then lowers the level ten times faster than it rises. Once the level falls under the disable threshold, the block clears it and goes through a full soft start. An external disable forces the level to zero, and releasing it starts a fresh ramp.

The fault flags are asynchronous, so each passes through two flops before the sequencer acts on it. A rate tick paces both ramps. The control word is a level sampled every cycle and not a stream, so every pin is a plain wire with no handshake.

Top module: `softstart_seq`

## Requirements
- R1: Supply lockout has hysteresis. The supply counts as good once the sampled code is at or above START_CODE. It stops counting as good only when the code drops below STOP_CODE. A code between the two keeps the previous verdict.
- R2: A bad supply or a low `ref_good` sets the level to zero and drops `out_en`. This happens within three clock edges for `ref_good`, which passes two synchronizer flops, and within two edges for the supply code.
- R3: During a soft start, each cycle with `rate_tick` high raises the level by exactly one code.
- R4: The level stops at LEVEL_MAX and never wraps. Reaching LEVEL_MAX moves the sequencer into the run state.
- R5: An overcurrent flag seen while ramping or running drops `out_en`. After that, each tick lowers the level by STOP_MULT codes, or to zero if less than STOP_MULT remains.
- R6: During a soft stop, a level below DIS_THR is cleared to zero and the sequencer returns to off. It starts a new soft start from zero once neither overcurrent nor disable is asserted.
- R7: An external disable while ramping or running sets the level to zero and holds it there, whatever the ticks do. Releasing the disable starts a soft start from zero.
- R8: `out_en` is high only while ramping or running and only when the level is at or above DIS_THR.
- R9: Outside the run state, `ctrl_out` is the smaller of `ctrl_in` and the level. In the run state, `ctrl_out` equals `ctrl_in` unchanged, even when `ctrl_in` is above LEVEL_MAX.
- R10: Priority is hard fault first, then overcurrent, then external disable. If overcurrent and disable arrive together, a soft stop follows. A hard fault during a soft stop clears the level at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_code | input | SUPPLY_W | Sampled supply voltage code |
| ref_good | input | 1 | Reference is in range (asynchronous) |
| ext_disable | input | 1 | External shutdown request (asynchronous) |
| overcurrent | input | 1 | Overcurrent comparator trip (asynchronous) |
| rate_tick | input | 1 | One-cycle pulse that paces both ramps |
| ctrl_in | input | LEVEL_W | PWM control word from the loop |
| ss_level | output | LEVEL_W | Current soft-start level |
| ctrl_out | output | LEVEL_W | Control word after the clamp |
| out_en | output | 1 | Output stage enable |

## Verification
The bench parks the supply code inside the hysteresis band in both directions. A design that compares against a single threshold would either restart or shut down there. It counts soft-stop ticks to the exact level where the cleanup happens: a design that tests the threshold off by one, or that skips the return to zero, would show a wrong level or would resume ramping from the old value. It asserts overcurrent and disable in the same cycle, and adds a reference fault during a soft stop. Swapped priorities would show as a level of zero where a slow ramp-down is expected, or the reverse. It also drives a control word above the maximum level during the run state, which catches a design that keeps clamping after the ramp has finished.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [1:0] {
    SS_OFF  = 2'd0,
    SS_RAMP = 2'd1,
    SS_RUN  = 2'd2,
    SS_STOP = 2'd3
  } ss_state_e;
endpackage

// File: rtl/ss_sync2.sv
module ss_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] out_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        out_q[i]  <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        out_q[i]  <= meta_q[i];
      end
    end
  end

  assign q = out_q;
endmodule

// File: rtl/ss_uvlo.sv
module ss_uvlo #(
  parameter int SUPPLY_W   = 8,
  parameter int START_CODE = 176,
  parameter int STOP_CODE  = 144
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SUPPLY_W-1:0] code_i,
  output logic                ok_o
);
  localparam logic [SUPPLY_W-1:0] StartL = SUPPLY_W'(START_CODE);
  localparam logic [SUPPLY_W-1:0] StopL  = SUPPLY_W'(STOP_CODE);

  logic ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ok_q <= 1'b0;
    else if (!ok_q && code_i >= StartL) ok_q <= 1'b1;
    else if (ok_q && code_i < StopL)    ok_q <= 1'b0;
  end

  assign ok_o = ok_q;

  // R1
  uvlo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(code_i) >= StartL);
  // R1
  uvlo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ok_q) |-> $past(code_i) < StopL);
endmodule

// File: rtl/ss_fsm.sv
module ss_fsm
  import softstart_pkg::*;
#(
  parameter int LEVEL_W   = 10,
  parameter int LEVEL_MAX = 1000,
  parameter int DIS_THR   = 100,
  parameter int STOP_MULT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hard_i,
  input  logic               ocp_i,
  input  logic               dis_i,
  input  logic               tick_i,
  output ss_state_e          state_o,
  output logic [LEVEL_W-1:0] level_o
);
  localparam logic [LEVEL_W-1:0] MaxL  = LEVEL_W'(LEVEL_MAX);
  localparam logic [LEVEL_W-1:0] ThrL  = LEVEL_W'(DIS_THR);
  localparam logic [LEVEL_W-1:0] StepL = LEVEL_W'(STOP_MULT);

  ss_state_e          st_q;
  logic [LEVEL_W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SS_OFF;
      lvl_q <= '0;
    end else if (hard_i) begin
      st_q  <= SS_OFF;
      lvl_q <= '0;
    end else begin
      case (st_q)
        SS_OFF: begin
          lvl_q <= '0;
          if (!ocp_i && !dis_i) st_q <= SS_RAMP;
        end
        SS_RAMP, SS_RUN: begin
          if (ocp_i) begin
            st_q <= SS_STOP;
          end else if (dis_i) begin
            st_q  <= SS_OFF;
            lvl_q <= '0;
          end else if (st_q == SS_RAMP) begin
            if (lvl_q >= MaxL)  st_q  <= SS_RUN;
            else if (tick_i)    lvl_q <= lvl_q + 1'b1;
          end
        end
        SS_STOP: begin
          if (lvl_q < ThrL) begin
            st_q  <= SS_OFF;
            lvl_q <= '0;
          end else if (tick_i) begin
            lvl_q <= (lvl_q < StepL) ? '0 : lvl_q - StepL;
          end
        end
        default: begin
          st_q  <= SS_OFF;
          lvl_q <= '0;
        end
      endcase
    end
  end

  assign state_o = st_q;
  assign level_o = lvl_q;

  // R4
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= MaxL);
  // R2
  hard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_i |=> (lvl_q == '0 && st_q == SS_OFF));
  // R3
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SS_RAMP && tick_i && !hard_i && !ocp_i && !dis_i && lvl_q < MaxL)
      |=> lvl_q == $past(lvl_q) + 1'b1);
  // R5
  stop_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SS_STOP) |=> lvl_q <= $past(lvl_q));
  // R10
  ocp_over_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SS_RUN || st_q == SS_RAMP) && ocp_i && !hard_i) |=> st_q == SS_STOP);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int SUPPLY_W   = 8,
  parameter int LEVEL_W    = 10,
  parameter int START_CODE = 176,
  parameter int STOP_CODE  = 144,
  parameter int LEVEL_MAX  = 1000,
  parameter int DIS_THR    = 100,
  parameter int STOP_MULT  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SUPPLY_W-1:0] supply_code,
  input  logic                ref_good,
  input  logic                ext_disable,
  input  logic                overcurrent,
  input  logic                rate_tick,
  input  logic [LEVEL_W-1:0]  ctrl_in,
  output logic [LEVEL_W-1:0]  ss_level,
  output logic [LEVEL_W-1:0]  ctrl_out,
  output logic                out_en
);
  localparam logic [LEVEL_W-1:0] ThrL = LEVEL_W'(DIS_THR);

  logic [2:0]         raw_flags;
  logic [2:0]         syn_flags;
  logic               supply_ok;
  logic               hard_fault;
  ss_state_e          state;
  logic [LEVEL_W-1:0] level;

  assign raw_flags = {~ref_good, overcurrent, ext_disable};

  ss_sync2 #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_flags),
    .q     (syn_flags)
  );

  ss_uvlo #(
    .SUPPLY_W  (SUPPLY_W),
    .START_CODE(START_CODE),
    .STOP_CODE (STOP_CODE)
  ) u_uvlo (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (supply_code),
    .ok_o   (supply_ok)
  );

  assign hard_fault = !supply_ok || syn_flags[2];

  ss_fsm #(
    .LEVEL_W  (LEVEL_W),
    .LEVEL_MAX(LEVEL_MAX),
    .DIS_THR  (DIS_THR),
    .STOP_MULT(STOP_MULT)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .hard_i  (hard_fault),
    .ocp_i   (syn_flags[1]),
    .dis_i   (syn_flags[0]),
    .tick_i  (rate_tick),
    .state_o (state),
    .level_o (level)
  );

  always_comb begin
    out_en   = (state == SS_RAMP || state == SS_RUN) && (level >= ThrL);
    ss_level = level;
    if (state == SS_RUN) ctrl_out = ctrl_in;
    else                 ctrl_out = (ctrl_in < level) ? ctrl_in : level;
  end

  // R8
  en_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> ss_level >= ThrL);
  // R9
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> ctrl_out <= ss_level);
  // R5
  ocp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_flags[1] && !hard_fault) |=> !out_en);
endmodule

// File: tb/test_softstart_seq.sv
module test_softstart_seq;
  localparam int SW = 8;
  localparam int LW = 10;
  localparam int MAXL = 100;
  localparam int THR = 20;
  localparam int STEP = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] supply_code = 8'd100;
  logic          ref_good = 1'b1;
  logic          ext_disable = 1'b0;
  logic          overcurrent = 1'b0;
  logic          rate_tick = 1'b0;
  logic [LW-1:0] ctrl_in = '0;
  logic [LW-1:0] ss_level;
  logic [LW-1:0] ctrl_out;
  logic          out_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  softstart_seq #(
    .SUPPLY_W(SW), .LEVEL_W(LW), .START_CODE(176), .STOP_CODE(144),
    .LEVEL_MAX(MAXL), .DIS_THR(THR), .STOP_MULT(STEP)
  ) i_softstart_seq (
    .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .ref_good(ref_good),
    .ext_disable(ext_disable), .overcurrent(overcurrent), .rate_tick(rate_tick),
    .ctrl_in(ctrl_in), .ss_level(ss_level), .ctrl_out(ctrl_out), .out_en(out_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rate_tick = 1'b1;
      @(negedge clk); rate_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 reset out_en", out_en, 0);
    check("R2 reset level", ss_level, 0);
    check("R9 reset ctrl_out", ctrl_out, 0);
  endtask

  task automatic t_start_ramp;
    supply_code = 8'd170; ctrl_in = 10'd90;
    idle(4); ticks(5);
    check("R1 below start level", ss_level, 0);
    supply_code = 8'd176;
    idle(4); ticks(19);
    check("R3 ramp level", ss_level, 19);
    check("R8 below thr out_en", out_en, 0);
    check("R9 ramp clamp", ctrl_out, 19);
    ticks(1);
    check("R8 at thr out_en", out_en, 1);
    idle(3);
    check("R3 no tick no step", ss_level, 20);
  endtask

  task automatic t_saturate;
    ticks(MAXL - 20 + 10);
    idle(2);
    check("R4 saturate", ss_level, MAXL);
    ctrl_in = 10'd300;
    @(negedge clk);
    check("R9 run passthrough", ctrl_out, 300);
    ctrl_in = 10'd40;
  endtask

  task automatic t_hysteresis;
    supply_code = 8'd150; idle(4);
    check("R1 in band keeps run", ss_level, MAXL);
    supply_code = 8'd140; idle(2);
    check("R2 uv clears level", ss_level, 0);
    check("R2 uv out_en", out_en, 0);
    supply_code = 8'd150; idle(4); ticks(5);
    check("R1 in band no restart", ss_level, 0);
    supply_code = 8'd180; idle(4); ticks(MAXL + 2); idle(2);
    check("R1 restart to max", ss_level, MAXL);
  endtask

  task automatic t_ref;
    ref_good = 1'b0; idle(3);
    check("R2 ref clears level", ss_level, 0);
    check("R2 ref out_en", out_en, 0);
    ref_good = 1'b1; idle(4); ticks(MAXL + 2); idle(2);
  endtask

  task automatic t_ocp;
    check("R5 pre ocp level", ss_level, MAXL);
    overcurrent = 1'b1; idle(4);
    check("R5 ocp out_en", out_en, 0);
    check("R5 ocp level held", ss_level, MAXL);
    ticks(1);
    check("R5 stop step", ss_level, MAXL - STEP);
    check("R9 stop clamp", ctrl_out, 40);
    ticks(7);
    check("R6 at thr level", ss_level, 20);
    check("R9 stop clamp low", ctrl_out, 20);
    ticks(1); idle(2);
    check("R6 cleared below thr", ss_level, 0);
    ticks(3);
    check("R6 hold while ocp", ss_level, 0);
    overcurrent = 1'b0; idle(4); ticks(5);
    check("R6 full soft start", ss_level, 5);
  endtask

  task automatic t_disable;
    ticks(45);
    check("R7 pre level", ss_level, 50);
    ext_disable = 1'b1; idle(4);
    check("R7 disable level", ss_level, 0);
    check("R7 disable out_en", out_en, 0);
    ticks(3);
    check("R7 ticks ignored", ss_level, 0);
    ext_disable = 1'b0; idle(4); ticks(5);
    check("R7 restart level", ss_level, 5);
    ticks(MAXL); idle(2);
  endtask

  task automatic t_priority;
    ext_disable = 1'b1; overcurrent = 1'b1; idle(4);
    check("R10 ocp over disable", ss_level, MAXL);
    ticks(1);
    check("R10 soft stop step", ss_level, MAXL - STEP);
    ref_good = 1'b0; idle(4);
    check("R10 hard over ocp", ss_level, 0);
    ref_good = 1'b1; ext_disable = 1'b0; overcurrent = 1'b0;
    idle(4); ticks(3);
    check("R10 recovery", ss_level, 3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_start_ramp();
    t_saturate();
    t_hysteresis();
    t_ref();
    t_ocp();
    t_disable();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule